// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block is the local monitor that sits beside one processor's load/store path and decides whether a store-exclusive may write. A load-exclusive request records a reservation on the cache line that holds its address. A later store-exclusive is allowed to write only when the monitor still holds a reservation and the store's address falls in that same line. The monitor reports the outcome on a status output. A clear-exclusive command drops the reservation, so an operating system can issue it on every context switch.

The monitor keeps exactly one reservation. There are two states, Open and Exclusive, and reset selects Open. If two exclusive sequences are interleaved, the newer load-exclusive overwrites the older reservation. The reservation granule is a whole line of `LINE_BYTES` bytes, which is 32 bytes by default. Any store-exclusive ends the reservation, whether it succeeds or fails.

The effect of an ordinary store to the reserved line is implementation-defined, so a parameter fixes it. With the default, `PLAIN_HIT_CLEARS = 0`, such a store leaves the reservation in place. With `PLAIN_HIT_CLEARS = 1`, an ordinary store that hits the reserved line drops the reservation.

The response is combinational and reflects the request presented in the current cycle. The reservation itself updates on the next rising clock edge.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is Open. A store-exclusive (`req_op` = 2'b01) issued before any load-exclusive fails, which means `st_permit` = 0 and `stex_fail` = 1.
- R2: A load-exclusive (`req_op` = 2'b00) records the line number `req_addr[ADDR_W-1:5]` and enters Exclusive. Its response is `st_permit` = 0 and `stex_fail` = 0.
- R3: A store-exclusive (`req_op` = 2'b01) issued in Exclusive succeeds when its line number equals the reserved one. Address bits [4:0] play no part in this comparison. Success is shown as `st_permit` = 1 and `stex_fail` = 0.
- R4: A store-exclusive to any other line, or one issued while Open, fails with `st_permit` = 0 and `stex_fail` = 1.
- R5: Every store-exclusive returns the monitor to Open, whatever its outcome. A second store-exclusive to the same line therefore fails.
- R6: A clear-exclusive (`req_op` = 2'b10) returns the monitor to Open. Its response is `st_permit` = 0 and `stex_fail` = 0.
- R7: A load-exclusive issued while Exclusive replaces the reservation. After it, only the newer line can succeed.
- R8: An ordinary store (`req_op` = 2'b11) gives `st_permit` = 1 and `stex_fail` = 0. With `PLAIN_HIT_CLEARS` = 0 it never changes the reservation. With `PLAIN_HIT_CLEARS` = 1 it drops the reservation when it hits the reserved line and leaves it alone otherwise.
- R9: While `req_valid` = 0 the monitor ignores `req_op` and `req_addr`. Its state does not change, and the response is `st_permit` = 0 and `stex_fail` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 00 load-exclusive, 01 store-exclusive, 10 clear-exclusive, 11 ordinary store |
| req_addr | input | ADDR_W | Byte address of the request |
| st_permit | output | 1 | The store of this cycle may write |
| stex_fail | output | 1 | The store-exclusive of this cycle failed (0 means success) |

## Verification
For every byte offset inside a line, the bench checks that store-exclusive succeeds. A monitor that compares a few too many address bits would fail some of these legal stores. It also checks that the neighbouring lines on both sides fail, which catches a monitor that compares too few bits. Follow-on store-exclusives catch a monitor that keeps its reservation after a store-exclusive, whether that store passed or failed, since the follow-on would wrongly succeed. Interleaved load-exclusives catch a monitor that keeps the older line. Two instances built with opposite ordinary-store policies must differ only on a store that hits the reserved line. A request with `req_valid` low is presented with a clearing opcode, and the bench expects the reservation to survive it.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    OP_LDEX  = 2'b00,
    OP_STEX  = 2'b01,
    OP_CLREX = 2'b10,
    OP_STORE = 2'b11
  } excl_op_e;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } mon_state_e;

  // Number of offset bits inside a reservation granule.
  function automatic int unsigned offset_bits(input int unsigned line_bytes);
    return $clog2(line_bytes);
  endfunction

endpackage

// File: rtl/excl_op_decode.sv
module excl_op_decode
  import excl_mon_pkg::*;
(
  input  logic       req_valid,
  input  logic [1:0] req_op,
  output logic       ev_ldex,
  output logic       ev_stex,
  output logic       ev_clrex,
  output logic       ev_store
);
  excl_op_e op;
  assign op = excl_op_e'(req_op);

  always_comb begin
    ev_ldex  = 1'b0;
    ev_stex  = 1'b0;
    ev_clrex = 1'b0;
    ev_store = 1'b0;
    if (req_valid) begin
      unique case (op)
        OP_LDEX:  ev_ldex  = 1'b1;
        OP_STEX:  ev_stex  = 1'b1;
        OP_CLREX: ev_clrex = 1'b1;
        OP_STORE: ev_store = 1'b1;
        default:  ev_store = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/excl_granule_cmp.sv
module excl_granule_cmp #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
  localparam int unsigned TAG_W     = ADDR_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  held_tag,
  output logic [TAG_W-1:0]  addr_tag,
  output logic              tag_match
);
  assign addr_tag  = addr[ADDR_W-1:OFS_W];
  assign tag_match = (addr_tag == held_tag);
endmodule

// File: rtl/excl_state_reg.sv
module excl_state_reg
  import excl_mon_pkg::*;
#(
  parameter int unsigned TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_res,
  input  logic             drop_res,
  input  logic [TAG_W-1:0] new_tag,
  output mon_state_e       state,
  output logic [TAG_W-1:0] tag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MON_OPEN;
      tag   <= '0;
    end else if (set_res) begin
      state <= MON_EXCL;
      tag   <= new_tag;
    end else if (drop_res) begin
      state <= MON_OPEN;
    end
  end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int unsigned ADDR_W           = 32,
  parameter int unsigned LINE_BYTES       = 32,
  parameter bit          PLAIN_HIT_CLEARS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              st_permit,
  output logic              stex_fail
);
  localparam int unsigned OFS_W = offset_bits(LINE_BYTES);
  localparam int unsigned TAG_W = ADDR_W - OFS_W;

  logic ev_ldex, ev_stex, ev_clrex, ev_store;
  logic [TAG_W-1:0] req_tag, held_tag;
  logic tag_match, res_hit, stex_ok, plain_drop, set_res, drop_res;
  mon_state_e state;

  excl_op_decode u_dec (
    .req_valid(req_valid), .req_op(req_op),
    .ev_ldex(ev_ldex), .ev_stex(ev_stex), .ev_clrex(ev_clrex), .ev_store(ev_store)
  );

  excl_granule_cmp #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_cmp (
    .addr(req_addr), .held_tag(held_tag), .addr_tag(req_tag), .tag_match(tag_match)
  );

  assign res_hit = (state == MON_EXCL) && tag_match;
  assign stex_ok = ev_stex && res_hit;

  generate
    if (PLAIN_HIT_CLEARS) begin : g_plain_clears
      assign plain_drop = ev_store && res_hit;
    end else begin : g_plain_keeps
      assign plain_drop = 1'b0;
    end
  endgenerate

  assign set_res  = ev_ldex;
  assign drop_res = ev_stex || ev_clrex || plain_drop;

  excl_state_reg #(.TAG_W(TAG_W)) u_state (
    .clk(clk), .rst_n(rst_n), .set_res(set_res), .drop_res(drop_res),
    .new_tag(req_tag), .state(state), .tag(held_tag)
  );

  assign st_permit = ev_store || stex_ok;
  assign stex_fail = ev_stex && !stex_ok;

  AST_OPEN_STEX_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01 && state == MON_OPEN) |-> (stex_fail && !st_permit)); // R4
  AST_STEX_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01) |-> (st_permit != stex_fail)); // R3
  AST_LDEX_RECORDS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b00) |=> (state == MON_EXCL && held_tag == $past(req_addr[ADDR_W-1:OFS_W]))); // R2
  AST_STEX_TO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b01) |=> (state == MON_OPEN)); // R5
  AST_CLREX_TO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b10) |=> (state == MON_OPEN)); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(state) && $stable(held_tag))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!st_permit && !stex_fail)); // R9
  AST_PLAIN_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'b11) |-> (st_permit && !stex_fail)); // R8

  generate
    if (!PLAIN_HIT_CLEARS) begin : g_ast_keep
      AST_PLAIN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'b11) |=> $stable(state)); // R8
    end
  endgenerate
endmodule

// File: tb/tb_excl_monitor.sv
`timescale 1ns/1ps
module tb_excl_monitor;
  localparam int AW = 32;
  localparam logic [1:0] LD = 2'b00, SX = 2'b01, CL = 2'b10, ST = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic permit_a, fail_a, permit_b, fail_b;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .LINE_BYTES(32), .PLAIN_HIT_CLEARS(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .st_permit(permit_a), .stex_fail(fail_a));

  excl_monitor #(.ADDR_W(AW), .LINE_BYTES(32), .PLAIN_HIT_CLEARS(1'b1)) dut_clr (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .st_permit(permit_b), .stex_fail(fail_b));

  function automatic logic [AW-1:0] line_addr(input longint unsigned line, input int unsigned ofs);
    return AW'((line << 5) + longint'(ofs % 32));
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {permit,fail} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Present one request for one cycle; compare response of both instances.
  task automatic issue(input string req, input logic v, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic [1:0] exp_a, input logic [1:0] exp_b);
    @(negedge clk);
    req_valid = v; req_op = op; req_addr = a;
    #1;
    check(req, {permit_a, fail_a}, exp_a);
    check({req, " (clearing store policy)"}, {permit_b, fail_b}, exp_b);
    @(posedge clk);
    #0.5;
    req_valid = 1'b0;
  endtask

  localparam logic [1:0] OK = 2'b10, BAD = 2'b01, NONE = 2'b00;

  initial begin : watchdog
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    longint unsigned lines [4];
    lines[0] = 0; lines[1] = 1; lines[2] = 64'h5A5A5; lines[3] = 64'h7FFFFFE;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset idle", {permit_a, fail_a}, NONE);
    rst_n = 1'b1;
    // R1: Open after reset
    issue("R1 stex after reset", 1'b1, SX, line_addr(3, 4), BAD, BAD);

    // R2/R3/R4/R5: every offset in the line succeeds, neighbours fail
    foreach (lines[i]) begin
      for (int o = 0; o < 32; o++) begin
        issue("R2 ldex", 1'b1, LD, line_addr(lines[i], (o * 7 + 3)), NONE, NONE);
        issue("R3 stex same line", 1'b1, SX, line_addr(lines[i], o), OK, OK);
        issue("R5 stex after success", 1'b1, SX, line_addr(lines[i], o), BAD, BAD);
      end
      for (int o = 0; o < 32; o += 5) begin
        issue("R2 ldex", 1'b1, LD, line_addr(lines[i], o), NONE, NONE);
        issue("R4 stex next line", 1'b1, SX, line_addr(lines[i] + 1, o), BAD, BAD);
        issue("R5 stex after fail", 1'b1, SX, line_addr(lines[i], o), BAD, BAD);
        if (lines[i] > 0) begin
          issue("R2 ldex", 1'b1, LD, line_addr(lines[i], o), NONE, NONE);
          issue("R4 stex prev line", 1'b1, SX, line_addr(lines[i] - 1, 31 - o), BAD, BAD);
        end
      end
    end

    // R6: clear drops reservation
    issue("R2 ldex", 1'b1, LD, line_addr(9, 0), NONE, NONE);
    issue("R6 clrex", 1'b1, CL, line_addr(9, 0), NONE, NONE);
    issue("R6 stex after clrex", 1'b1, SX, line_addr(9, 0), BAD, BAD);

    // R7: interleaved ldex replaces
    issue("R2 ldex A", 1'b1, LD, line_addr(20, 8), NONE, NONE);
    issue("R7 ldex B", 1'b1, LD, line_addr(40, 8), NONE, NONE);
    issue("R7 stex old line", 1'b1, SX, line_addr(20, 8), BAD, BAD);
    issue("R2 ldex A", 1'b1, LD, line_addr(20, 8), NONE, NONE);
    issue("R7 ldex B", 1'b1, LD, line_addr(40, 8), NONE, NONE);
    issue("R7 stex new line", 1'b1, SX, line_addr(40, 12), OK, OK);
    issue("R7 ldex same line again", 1'b1, LD, line_addr(40, 0), NONE, NONE);
    issue("R7 ldex same line again", 1'b1, LD, line_addr(40, 4), NONE, NONE);
    issue("R7 stex after repeat", 1'b1, SX, line_addr(40, 31), OK, OK);

    // R8: ordinary store policies
    issue("R2 ldex", 1'b1, LD, line_addr(70, 0), NONE, NONE);
    issue("R8 store hit", 1'b1, ST, line_addr(70, 16), OK, OK);
    issue("R8 stex after store hit", 1'b1, SX, line_addr(70, 0), OK, BAD);
    issue("R2 ldex", 1'b1, LD, line_addr(70, 0), NONE, NONE);
    issue("R8 store miss", 1'b1, ST, line_addr(71, 0), OK, OK);
    issue("R8 stex after store miss", 1'b1, SX, line_addr(70, 0), OK, OK);
    issue("R8 store while open", 1'b1, ST, line_addr(70, 0), OK, OK);
    issue("R8 stex open after store", 1'b1, SX, line_addr(70, 0), BAD, BAD);

    // R9: invalid requests ignored
    issue("R2 ldex", 1'b1, LD, line_addr(90, 0), NONE, NONE);
    issue("R9 invalid clrex", 1'b0, CL, line_addr(90, 0), NONE, NONE);
    issue("R9 invalid stex", 1'b0, SX, line_addr(90, 0), NONE, NONE);
    issue("R9 invalid ldex", 1'b0, LD, line_addr(91, 0), NONE, NONE);
    issue("R9 invalid store hit", 1'b0, ST, line_addr(90, 0), NONE, NONE);
    issue("R9 stex after invalids", 1'b1, SX, line_addr(90, 0), OK, OK);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule